// File: doc/BRIEF.md
# Receive Interrupt Queue and Error Interrupt Controller

This block sits behind the receive side of a ring node that keeps a replicated copy of shared memory. Each incoming message arrives as a one-cycle strobe with its 23-bit byte address, an interrupt flag, a retry flag and a flag that marks whether the message has come back to the node that sent it. For every message the block decides two things:

- whether the data is written into local memory, signalled by a registered write strobe and address;
- whether the message's word address, together with its retry bit, is queued in an interrupt FIFO for the host.

The per-word receive-interrupt-enable bit is read from a side control RAM and arrives with the message. A register override can stand in for it.

Alongside the queue the block keeps a 16-bit error register. Some of its bits are sticky latches that clear when the register is read. The others follow their event inputs live. A mask selects which error bits may interrupt.

A single host interrupt line is raised for either source: a non-empty queue or a masked error. Once raised, the line stays high until the host writes the error register. That write also re-arms the line.

The message input carries no ready signal and never stalls. A message that would be queued while the FIFO is full is dropped from the queue, and the full condition is latched as an error. Its memory write still happens.

The queue is read through two 16-bit readout words. Each read strobe on the upper word pops one entry.

Top module: `rx_irq_ctrl`

## Requirements
- R1: Messages are acted on only in a cycle where `msg_valid` and `ctl_rx_en` are both 1. With `ctl_rx_en` at 0 there is no memory write and no queue entry.
- R2: An accepted foreign message (`msg_native`=0) always produces a memory write. `mem_wr` and `mem_addr` appear one cycle after the message.
- R3: An accepted foreign message with `msg_int`=1 is queued only when `ctl_mme`=1 and (`acr_rie`=1 or `ctl_rie_ovr`=1).
- R4: An accepted native message (`msg_native`=1) is written to memory only when `ctl_own_wr_en`=1. It is queued only when `ctl_own_irq_en`=1 and the queuing condition of R3 also holds.
- R5: `irq_lo` shows address bits 15..2 in its bits 15..2 and reads 0 in bits 1..0. `irq_hi` shows address bits 22..16 in bits 6..0, the entry's retry bit in bit 14, the not-empty flag in bit 15, and 0 in bits 13..7.
- R6: The queue is first-in first-out with `FIFO_DEPTH` entries. A queue request made while the queue is full is dropped, and the stored entries are unchanged.
- R7: A one-cycle `irq_pop` pops the head entry. A pop while the queue is empty changes nothing, and while empty both readout words are 0.
- R8: Error bits 0, 2, 4 and 6..13 are sticky. Each is set by a pulse on the matching `err_evt` bit, and bit 4 is also set by a full queue. A one-cycle `err_rd` clears them, but an event in the same cycle wins. Bits 1, 3, 5, 14 and 15 follow `err_evt` directly.
- R9: An error interrupt cause exists only when `ctl_irq_on_err`=1 and some bit of `err_reg` is 1 in `err_mask`. A queue cause exists when `ctl_mme`=1 and the queue is not empty.
- R10: With `ctl_host_ie`=1 and the line armed, a cause raises `host_irq` on the next clock. With `ctl_host_ie`=0 it is never raised.
- R11: Once high, `host_irq` stays high, even after its cause is gone, until `err_wr` is pulsed. That clears it and re-arms it, so a cause still present raises it again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Received message strobe, one cycle |
| msg_addr | input | 23 | Byte address of the message |
| msg_int | input | 1 | Message carries the interrupt flag |
| msg_retry | input | 1 | Message carries the retry flag |
| msg_native | input | 1 | Message originated at this node |
| acr_rie | input | 1 | Side-RAM receive-interrupt-enable bit for the word |
| ctl_rx_en | input | 1 | Receive enable |
| ctl_mme | input | 1 | Mask-match (queue) enable |
| ctl_rie_ovr | input | 1 | Override of the per-word enable |
| ctl_own_wr_en | input | 1 | Write own returning messages to memory |
| ctl_own_irq_en | input | 1 | Allow own returning messages to interrupt |
| ctl_irq_on_err | input | 1 | Interrupt on errors enable |
| ctl_host_ie | input | 1 | Host interrupt enable |
| err_evt | input | 16 | Error event pulses / live status levels |
| err_mask | input | 16 | Error interrupt mask |
| err_rd | input | 1 | Error register read strobe (clears sticky bits) |
| err_wr | input | 1 | Error register write strobe (re-arms interrupt) |
| irq_pop | input | 1 | Upper readout read strobe, pops one entry |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 23 | Memory write address |
| err_reg | output | 16 | Error register value |
| irq_lo | output | 16 | Lower interrupt readout word |
| irq_hi | output | 16 | Upper interrupt readout word |
| host_irq | output | 1 | Host interrupt line |

## Verification
The assertions take for granted that `msg_valid`, `err_rd`, `err_wr` and `irq_pop` are single-cycle strobes driven from clean registers. They also assume that control bits change only between messages. The queue-count properties further assume the host never pops and writes the error register in a way that depends on same-edge outputs. The bench changes every input only on the falling edge and holds the control bits steady around each message. It pulses each strobe for exactly one cycle, and it reads the readout words before issuing the pop that changes them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W = 23;
  localparam int ERR_W  = 16;
  localparam int FULL_BIT = 4;
  // sticky error positions: 0, 2, 4, 6..13
  localparam logic [ERR_W-1:0] STICKY = 16'h3FD5;

  typedef struct packed {
    logic              retry;
    logic [ADDR_W-3:0] waddr;
  } irq_ent_t;
endpackage

// File: rtl/rxq_decide.sv
module rxq_decide (
  input  logic valid,
  input  logic rx_en,
  input  logic native,
  input  logic int_flag,
  input  logic acr_rie,
  input  logic mme,
  input  logic rie_ovr,
  input  logic own_wr_en,
  input  logic own_irq_en,
  output logic wr,
  output logic push
);
  logic take, word_ok;

  always_comb begin
    take    = valid & rx_en;
    word_ok = mme & (acr_rie | rie_ovr);
    wr      = take & (native ? own_wr_en : 1'b1);
    push    = take & int_flag & word_ok & (native ? own_irq_en : 1'b1);
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == CMAX);
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX); // R6
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt == $past(cnt) && wp == $past(wp))); // R6
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (empty && $stable(rp))); // R7
endmodule

// File: rtl/rxq_errlat.sv
module rxq_errlat
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] evt,
  input  logic             q_full,
  input  logic             rd,
  output logic [ERR_W-1:0] rdata
);
  logic [ERR_W-1:0] lat, set_v;

  always_comb begin
    set_v = evt & STICKY;
    set_v[FULL_BIT] = set_v[FULL_BIT] | q_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else        lat <= (rd ? '0 : lat) | set_v;
  end

  assign rdata = lat | (evt & ~STICKY);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ((evt & STICKY) == '0) && !q_full) |=> ((rdata & STICKY) == '0)); // R8
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd) |=> ((rdata & STICKY & $past(rdata)) == ($past(rdata) & STICKY))); // R8
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rxq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic              msg_int,
  input  logic              msg_retry,
  input  logic              msg_native,
  input  logic              acr_rie,
  input  logic              ctl_rx_en,
  input  logic              ctl_mme,
  input  logic              ctl_rie_ovr,
  input  logic              ctl_own_wr_en,
  input  logic              ctl_own_irq_en,
  input  logic              ctl_irq_on_err,
  input  logic              ctl_host_ie,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic [ERR_W-1:0]  err_mask,
  input  logic              err_rd,
  input  logic              err_wr,
  input  logic              irq_pop,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ERR_W-1:0]  err_reg,
  output logic [15:0]       irq_lo,
  output logic [15:0]       irq_hi,
  output logic              host_irq
);
  localparam int EW = $bits(irq_ent_t);

  logic     wr_d, push_d, q_empty, q_full, err_hit, cause, armed;
  irq_ent_t ent_in, ent_out;

  rxq_decide u_decide (
    .valid      (msg_valid),
    .rx_en      (ctl_rx_en),
    .native     (msg_native),
    .int_flag   (msg_int),
    .acr_rie    (acr_rie),
    .mme        (ctl_mme),
    .rie_ovr    (ctl_rie_ovr),
    .own_wr_en  (ctl_own_wr_en),
    .own_irq_en (ctl_own_irq_en),
    .wr         (wr_d),
    .push       (push_d)
  );

  assign ent_in.retry = msg_retry;
  assign ent_in.waddr = msg_addr[ADDR_W-1:2];

  rxq_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_d),
    .din   (ent_in),
    .pop   (irq_pop),
    .dout  (ent_out),
    .empty (q_empty),
    .full  (q_full)
  );

  rxq_errlat u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (err_evt),
    .q_full (q_full),
    .rd     (err_rd),
    .rdata  (err_reg)
  );

  always_comb begin
    if (q_empty) begin
      irq_lo = '0;
      irq_hi = '0;
    end else begin
      irq_lo = {ent_out.waddr[13:0], 2'b00};
      irq_hi = {1'b1, ent_out.retry, 7'b0, ent_out.waddr[20:14]};
    end
  end

  assign err_hit = |(err_reg & err_mask);
  assign cause   = ctl_host_ie & ((ctl_mme & ~q_empty) | (ctl_irq_on_err & err_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      armed    <= 1'b1;
      host_irq <= 1'b0;
    end else begin
      mem_wr <= wr_d;
      if (wr_d) mem_addr <= msg_addr;
      if (err_wr) begin
        armed    <= 1'b1;
        host_irq <= 1'b0;
      end else if (armed && cause) begin
        armed    <= 1'b0;
        host_irq <= 1'b1;
      end
    end
  end

  AST_WR_NEEDS_RXEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(msg_valid && ctl_rx_en)); // R1
  AST_NATIVE_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_native && !ctl_own_wr_en) |=> !mem_wr); // R4
  AST_IRQ_NEEDS_HIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(ctl_host_ie)); // R10
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !err_wr) |=> host_irq); // R11
  AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |=> !host_irq); // R11
endmodule

// File: tb/rx_irq_ctrl_bench.sv
module rx_irq_ctrl_bench;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 0, msg_int = 0, msg_retry = 0, msg_native = 0, acr_rie = 0;
  logic [22:0] msg_addr = '0;
  logic        ctl_rx_en = 0, ctl_mme = 0, ctl_rie_ovr = 0, ctl_own_wr_en = 0;
  logic        ctl_own_irq_en = 0, ctl_irq_on_err = 0, ctl_host_ie = 0;
  logic [15:0] err_evt = '0, err_mask = '0;
  logic        err_rd = 0, err_wr = 0, irq_pop = 0;
  logic        mem_wr, host_irq;
  logic [22:0] mem_addr;
  logic [15:0] err_reg, irq_lo, irq_hi;

  int nvec = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  rx_irq_ctrl #(.FIFO_DEPTH(D)) u_rx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_int(msg_int), .msg_retry(msg_retry), .msg_native(msg_native),
    .acr_rie(acr_rie), .ctl_rx_en(ctl_rx_en), .ctl_mme(ctl_mme),
    .ctl_rie_ovr(ctl_rie_ovr), .ctl_own_wr_en(ctl_own_wr_en),
    .ctl_own_irq_en(ctl_own_irq_en), .ctl_irq_on_err(ctl_irq_on_err),
    .ctl_host_ie(ctl_host_ie), .err_evt(err_evt), .err_mask(err_mask),
    .err_rd(err_rd), .err_wr(err_wr), .irq_pop(irq_pop), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .err_reg(err_reg), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .host_irq(host_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [22:0] a, input logic it, input logic rt,
                      input logic nat, input logic rie);
    @(negedge clk);
    msg_valid = 1; msg_addr = a; msg_int = it; msg_retry = rt;
    msg_native = nat; acr_rie = rie;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic pulse_pop();
    irq_pop = 1; @(negedge clk); irq_pop = 0;
  endtask

  task automatic pulse_rd();
    err_rd = 1; @(negedge clk); err_rd = 0;
  endtask

  task automatic pulse_wr();
    err_wr = 1; @(negedge clk); err_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog all-R act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [22:0] exp_a [5];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R7 reset irq_hi", irq_hi, 0);
    check("R7 reset irq_lo", irq_lo, 0);
    check("R8 reset err_reg", err_reg, 0);
    check("R10 reset host_irq", host_irq, 0);
    check("R2 reset mem_wr", mem_wr, 0);

    // exhaustive sweep of the decision inputs: R1 R2 R3 R4
    for (int v = 0; v < 256; v++) begin
      logic rx, mme, ovr, ow, oi, rie, it, nat, ewr, epush;
      logic [22:0] a;
      rx = v[0]; mme = v[1]; ovr = v[2]; ow = v[3];
      oi = v[4]; rie = v[5]; it = v[6]; nat = v[7];
      ewr   = rx & (nat ? ow : 1'b1);
      epush = rx & it & mme & (rie | ovr) & (nat ? oi : 1'b1);
      a = 23'((v * 4099) << 2) | 23'(v & 3);
      @(negedge clk);
      ctl_rx_en = rx; ctl_mme = mme; ctl_rie_ovr = ovr;
      ctl_own_wr_en = ow; ctl_own_irq_en = oi;
      send(a, it, 1'b0, nat, rie);
      check(nat ? "R4 mem_wr native" : (rx ? "R2 mem_wr foreign" : "R1 mem_wr gated"),
            mem_wr, ewr);
      if (ewr) check("R2 mem_addr", mem_addr, a);
      check(nat ? "R4 queued native" : (rx ? "R3 queued foreign" : "R1 queue gated"),
            irq_hi[15], epush);
      if (epush) begin
        check("R5 irq_lo field", irq_lo, {a[15:2], 2'b00});
        pulse_pop();
      end
      check("R7 empty after pop", irq_hi, 0);
    end

    // fill beyond depth: R5 R6 R7 R8(bit 4)
    @(negedge clk);
    ctl_rx_en = 1; ctl_mme = 1; ctl_rie_ovr = 1; ctl_own_wr_en = 0; ctl_own_irq_en = 0;
    for (int i = 0; i < 5; i++) begin
      exp_a[i] = 23'h7F_0000 - 23'(i * 23'h1_1234);
      send(exp_a[i], 1'b1, logic'(i & 1), 1'b0, 1'b0);
    end
    check("R8 full latched bit4", err_reg[4], 1);
    for (int i = 0; i < D; i++) begin
      check("R5 irq_hi entry", irq_hi,
            {1'b1, logic'(i & 1), 7'b0, exp_a[i][22:16]});
      check("R5 irq_lo entry", irq_lo, {exp_a[i][15:2], 2'b00});
      pulse_pop();
    end
    check("R6 dropped entry absent", irq_hi, 0);
    pulse_pop();
    check("R7 pop empty lo", irq_lo, 0);
    send(23'h12_3456, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R7 queue intact after empty pop", irq_hi, {1'b1, 1'b1, 7'b0, 7'h12});
    pulse_pop();
    check("R8 bit4 still latched", err_reg[4], 1);
    pulse_rd();
    check("R8 read clears", err_reg, 0);

    // sticky versus live bits: R8
    err_evt = 16'h0003; @(negedge clk);
    err_evt = 16'h0002; @(negedge clk);
    check("R8 sticky+live", err_reg, 16'h0003);
    pulse_rd();
    check("R8 live survives read", err_reg, 16'h0002);
    err_evt = 16'h0000; #1;
    check("R8 live follows", err_reg, 0);
    err_evt = 16'h2000; err_rd = 1; @(negedge clk);
    err_evt = 0; err_rd = 0;
    check("R8 event wins over read", err_reg, 16'h2000);
    pulse_rd();
    for (int b = 0; b < 16; b++) begin
      logic sticky;
      sticky = (16'h3FD5 >> b) & 1;
      err_evt = 16'(1 << b); @(negedge clk);
      err_evt = 0; #1;
      check("R8 per-bit latch", err_reg, sticky ? (1 << b) : 0);
      pulse_rd();
    end

    // error interrupt: R9 R10 R11
    ctl_host_ie = 1; ctl_irq_on_err = 1; err_mask = 16'h0100;
    err_evt = 16'h0100; @(negedge clk);
    err_evt = 0; @(negedge clk);
    check("R10 error irq raised", host_irq, 1);
    pulse_rd();
    check("R11 irq held after cause gone", host_irq, 1);
    pulse_wr();
    check("R11 write rearms/clears", host_irq, 0);
    @(negedge clk);
    check("R11 no cause stays low", host_irq, 0);
    err_mask = 16'h0000;
    err_evt = 16'h0100; @(negedge clk); err_evt = 0;
    repeat (3) @(negedge clk);
    check("R9 masked error no irq", host_irq, 0);
    pulse_rd();
    err_mask = 16'h0100; ctl_irq_on_err = 0;
    err_evt = 16'h0100; @(negedge clk); err_evt = 0;
    repeat (3) @(negedge clk);
    check("R9 irq_on_err off", host_irq, 0);
    ctl_irq_on_err = 1;
    @(negedge clk);
    check("R10 armed cause fires", host_irq, 1);
    pulse_wr();
    @(negedge clk);
    check("R11 persistent cause refires", host_irq, 1);
    pulse_rd(); pulse_wr();
    @(negedge clk);
    check("R11 cleared cause quiet", host_irq, 0);

    // queue interrupt source: R9 R10
    send(23'h00_0040, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R10 one cycle after push", host_irq, 0);
    @(negedge clk);
    check("R9 queue irq", host_irq, 1);
    pulse_pop();
    check("R11 held after pop", host_irq, 1);
    pulse_wr();
    ctl_host_ie = 0;
    send(23'h00_0080, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 host_ie off blocks", host_irq, 0);
    pulse_pop();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule